// File: doc/BRIEF.md
# Three-Operand 4-bit Mini ALU

This block is a purely combinational arithmetic and logic unit for 4-bit data. It has three data inputs, `a`, `b` and `m`, a 4-bit operation code `op`, and a 4-bit result `r`. Input `a` is always the first operand. The code picks either `b` or `m` as the second operand. An operation is an addition, a subtraction, a bitwise AND, OR or XOR, or a bitwise inversion of one input. The unit makes no flags, no carry-out and no borrow.

The block has no clock, no registers and no handshake. A surrounding datapath presents the operands and a code, and reads `r` in the same cycle. Codes that name no operation produce an all-zero result, so `r` is never undefined. The design is split into four parts:

- a decoder that sorts each code into a class and an operand choice;
- an adder/subtractor;
- a bitwise unit;
- a final result selector.

Top module: `mini_alu`

## Requirements
- R1: `op` = 0 (binary 0000) gives `r` = (`a` + `b`) mod 16, and `op` = 1 (0001) gives `r` = (`a` + `m`) mod 16; the carry out of bit 3 is dropped.
- R2: `op` = 2 (0010) gives `r` = (`a` − `b`) mod 16, and `op` = 3 (0011) gives `r` = (`a` − `m`) mod 16; a borrow wraps the result and is not reported.
- R3: `op` = 4, 5 and 6 (0100, 0101, 0110) give the bitwise inverse of `a`, `b` and `m` respectively.
- R4: `op` = 7 (0111) gives `a` AND `b`, and `op` = 8 (1000) gives `a` AND `m`.
- R5: `op` = 9 (1001) gives `a` OR `b`, and `op` = 10 (1010) gives `a` OR `m`.
- R6: `op` = 11 (1011) gives `a` XOR `b`, and `op` = 12 (1100) gives `a` XOR `m`.
- R7: `op` = 13, 14 and 15 (1101, 1110, 1111) drive `r` to 0000 for every value of `a`, `b` and `m`.
- R8: Under every code, the input that the code does not name has no effect on `r`. `b` is unused for codes 1, 3, 4, 6, 8, 10 and 12. `m` is unused for codes 0, 2, 4, 5, 7, 9 and 11.
- R9: `r` follows its inputs with no clock. A change of any input between clock edges shows on `r` before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | First operand, used by every operation except the inversions of `b` and `m` |
| b | input | 4 | Primary second operand |
| m | input | 4 | Alternate second operand |
| op | input | 4 | Operation code, 0 to 12 defined, 13 to 15 give zero |
| r | output | 4 | Result |

## Verification
The `b` and `m` operand paths are both active at all times. The code only chooses which of them reaches the adder or the bitwise unit. A mis-decoded code would let the wrong operand, or a blend of both, appear together with the intended operation. The sweep tries this by applying all 4096 combinations of `a`, `b` and `m` under each of the 16 codes. In most vectors `b` and `m` differ, so any leak of the unused operand changes `r`. Every result is checked against a value computed arithmetically in the bench, with the same vectors also testing wraparound at 0 and 15.

// File: rtl/mini_alu_pkg.sv
package mini_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_B = 4'd0,
    OP_ADD_M = 4'd1,
    OP_SUB_B = 4'd2,
    OP_SUB_M = 4'd3,
    OP_INV_A = 4'd4,
    OP_INV_B = 4'd5,
    OP_INV_M = 4'd6,
    OP_AND_B = 4'd7,
    OP_AND_M = 4'd8,
    OP_OR_B  = 4'd9,
    OP_OR_M  = 4'd10,
    OP_XOR_B = 4'd11,
    OP_XOR_M = 4'd12
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_ARITH = 2'd1,
    CLS_LOGIC = 2'd2
  } alu_class_e;

  typedef enum logic [1:0] {
    LF_INV = 2'd0,
    LF_AND = 2'd1,
    LF_OR  = 2'd2,
    LF_XOR = 2'd3
  } logic_fn_e;

  typedef struct packed {
    alu_class_e cls;
    logic       sel_m;
    logic       is_sub;
    logic_fn_e  lfn;
    logic       inv_a;
  } alu_ctrl_t;

endpackage

// File: rtl/mini_alu_decode.sv
module mini_alu_decode
  import mini_alu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output alu_ctrl_t       ctrl
);

  always_comb begin
    ctrl = '{cls: CLS_NONE, sel_m: 1'b0, is_sub: 1'b0, lfn: LF_INV, inv_a: 1'b0};
    case (alu_op_e'(op))
      OP_ADD_B: ctrl.cls = CLS_ARITH;
      OP_ADD_M: begin ctrl.cls = CLS_ARITH; ctrl.sel_m = 1'b1; end
      OP_SUB_B: begin ctrl.cls = CLS_ARITH; ctrl.is_sub = 1'b1; end
      OP_SUB_M: begin ctrl.cls = CLS_ARITH; ctrl.is_sub = 1'b1; ctrl.sel_m = 1'b1; end
      OP_INV_A: begin ctrl.cls = CLS_LOGIC; ctrl.inv_a = 1'b1; end
      OP_INV_B: ctrl.cls = CLS_LOGIC;
      OP_INV_M: begin ctrl.cls = CLS_LOGIC; ctrl.sel_m = 1'b1; end
      OP_AND_B: begin ctrl.cls = CLS_LOGIC; ctrl.lfn = LF_AND; end
      OP_AND_M: begin ctrl.cls = CLS_LOGIC; ctrl.lfn = LF_AND; ctrl.sel_m = 1'b1; end
      OP_OR_B:  begin ctrl.cls = CLS_LOGIC; ctrl.lfn = LF_OR; end
      OP_OR_M:  begin ctrl.cls = CLS_LOGIC; ctrl.lfn = LF_OR; ctrl.sel_m = 1'b1; end
      OP_XOR_B: begin ctrl.cls = CLS_LOGIC; ctrl.lfn = LF_XOR; end
      OP_XOR_M: begin ctrl.cls = CLS_LOGIC; ctrl.lfn = LF_XOR; ctrl.sel_m = 1'b1; end
      default:  ctrl.cls = CLS_NONE;
    endcase
  end

endmodule

// File: rtl/mini_alu_arith.sv
module mini_alu_arith #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] opnd,
  input  logic         is_sub,
  output logic [W-1:0] res
);

  logic [W-1:0] sum;
  logic [W-1:0] diff;

  assign sum  = a + opnd;
  assign diff = a - opnd;
  assign res  = is_sub ? diff : sum;

  logic [W-1:0] back_add;
  logic [W-1:0] back_sub;
  assign back_add = res - opnd;
  assign back_sub = res + opnd;

  always_comb begin
    if (!is_sub) begin
      assert_sum_inverts_R1: assert (back_add == a)
        else $error("sum does not invert back to first operand");
    end else begin
      assert_diff_inverts_R2: assert (back_sub == a)
        else $error("difference does not invert back to first operand");
    end
  end

endmodule

// File: rtl/mini_alu_logic.sv
module mini_alu_logic
  import mini_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] opnd,
  input  logic_fn_e    lfn,
  input  logic         inv_a,
  output logic [W-1:0] res
);

  logic [W-1:0] inv_src;
  assign inv_src = inv_a ? a : opnd;

  always_comb begin
    case (lfn)
      LF_AND:  res = a & opnd;
      LF_OR:   res = a | opnd;
      LF_XOR:  res = a ^ opnd;
      default: res = ~inv_src;
    endcase
  end

  always_comb begin
    case (lfn)
      LF_AND: assert_and_subset_R4: assert (((res & ~a) == '0) && ((res & ~opnd) == '0))
                else $error("AND result has a bit set outside an operand");
      LF_OR:  assert_or_superset_R5: assert (((res & a) == a) && ((res & opnd) == opnd))
                else $error("OR result lost an operand bit");
      LF_XOR: assert_xor_undo_R6: assert ((res ^ opnd) == a)
                else $error("XOR result does not cancel");
      default: assert_inv_disjoint_R3: assert (((res & inv_src) == '0) && ((res | inv_src) == '1))
                else $error("inverse overlaps its source");
    endcase
  end

endmodule

// File: rtl/mini_alu.sv
module mini_alu
  import mini_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [W-1:0]    m,
  input  logic [OP_W-1:0] op,
  output logic [W-1:0]    r
);

  localparam logic [OP_W-1:0] LAST_DEFINED = OP_XOR_M;

  alu_ctrl_t    ctrl;
  logic [W-1:0] opnd;
  logic [W-1:0] arith_res;
  logic [W-1:0] logic_res;

  mini_alu_decode u_decode (
    .op   (op),
    .ctrl (ctrl)
  );

  assign opnd = ctrl.sel_m ? m : b;

  mini_alu_arith #(.W(W)) u_arith (
    .a      (a),
    .opnd   (opnd),
    .is_sub (ctrl.is_sub),
    .res    (arith_res)
  );

  mini_alu_logic #(.W(W)) u_logic (
    .a     (a),
    .opnd  (opnd),
    .lfn   (ctrl.lfn),
    .inv_a (ctrl.inv_a),
    .res   (logic_res)
  );

  always_comb begin
    case (ctrl.cls)
      CLS_ARITH: r = arith_res;
      CLS_LOGIC: r = logic_res;
      default:   r = '0;
    endcase
  end

  always_comb begin
    if (op > LAST_DEFINED) begin
      assert_reserved_zero_R7: assert (r == '0)
        else $error("reserved code produced a nonzero result");
    end
  end

endmodule

// File: tb/mini_alu_bench.sv
module mini_alu_bench;

  logic       clk = 1'b0;
  logic [3:0] a, b, m, op;
  logic [3:0] r;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  mini_alu u_mini_alu (
    .a  (a),
    .b  (b),
    .m  (m),
    .op (op),
    .r  (r)
  );

  function automatic logic [3:0] model(input int o, input int x, input int y, input int z);
    int v;
    case (o)
      0: v = x + y;
      1: v = x + z;
      2: v = x - y + 16;
      3: v = x - z + 16;
      4: v = 15 - x;
      5: v = 15 - y;
      6: v = 15 - z;
      7: v = x & y;
      8: v = x & z;
      9: v = x | y;
      10: v = x | z;
      11: v = x ^ y;
      12: v = x ^ z;
      default: v = 0;
    endcase
    return 4'(v % 16);
  endfunction

  function automatic string req_of(input int o);
    if (o <= 1) return "R1";
    if (o <= 3) return "R2";
    if (o <= 6) return "R3";
    if (o <= 8) return "R4";
    if (o <= 10) return "R5";
    if (o <= 12) return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    n_checks++;
    if (r !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%0d b=%0d m=%0d actual=%0d expected=%0d",
               req, op, a, b, m, r, exp);
    end
  endtask

  initial begin
    a = '0; b = '0; m = '0; op = '0;
    @(negedge clk);
    check("R1", 4'd0);          // all-zero start vector

    for (int o = 0; o < 16; o++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          for (int z = 0; z < 16; z++) begin
            @(posedge clk);
            #1;
            op = 4'(o); a = 4'(x); b = 4'(y); m = 4'(z);
            @(negedge clk);
            // R8: b and m differ in most vectors, so a leak of the unused operand miscompares
            check(req_of(o), model(o, x, y, z));
          end
        end
      end
    end

    // R9: change an input between edges and observe without any edge
    @(posedge clk);
    #1;
    op = 4'd0; a = 4'd15; b = 4'd1; m = 4'd7;
    #1;
    check("R9", 4'd0);
    a = 4'd3;
    #1;
    check("R9", 4'd4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule